// File: doc/BRIEF.md
# I2C Master Address-Phase Status Flags

This block holds two status flags for an I2C master controller. The first is the acknowledge-failure flag. The second is the end-of-address flag. A byte-level bus engine supplies single-cycle event strobes: an address byte went out, the receiver did not acknowledge a byte, a start condition was issued, and a repeated start was issued. The host side supplies the enable bit, the interrupt-enable bit, and strobes for two register accesses: a read of status register 2 and a write of the control register.

The end-of-address flag follows the addressing mode:
- In 7-bit mode, a single address byte completes the address phase.
- In 10-bit mode, the header byte and the low byte must both go out.
- In 10-bit mode, a read that follows a repeated start completes the address phase after the header byte alone.

Each flag has its own way of being cleared. A status read alone clears acknowledge-failure. End-of-address needs a status read and then a later control write. Clearing the enable forces both flags low. The block also drives an interrupt request and a permit signal for the SCL driver. The permit tells the driver whether it may stretch the clock.

Top module: `i2cm_addr_flags`

## Requirements
- R1: A `nack_i` pulse while `en_i`=1 sets `ack_fail_o` on the next clock edge.
- R2: `irq_o` is 1 exactly when `ack_fail_o`=1 and `irq_en_i`=1. The path is combinational from `irq_en_i`.
- R3: A `sr2_rd_i` pulse clears `ack_fail_o` on the next edge. If `nack_i` arrives in the same cycle, the flag stays set.
- R4: `stretch_ok_o` is 0 whenever `ack_fail_o` is 1, and 1 otherwise.
- R5: With `mode10_i`=0, an `addr_sent_i` pulse sets `addr_end_o` on the next edge.
- R6: With `mode10_i`=1, after a start the first `addr_sent_i` (the header) leaves `addr_end_o` at 0. The second `addr_sent_i` (the low byte) sets it.
- R7: With `mode10_i`=1, after `rstart_i` the next `addr_sent_i` sets `addr_end_o` at once if `rd_dir_i`=1 (1 = read). If `rd_dir_i`=0, a low byte is still required.
- R8: `addr_end_o` clears only on a `cr_wr_i` that comes in a cycle after a `sr2_rd_i` seen while the flag was set. A status read alone, or a control write with no earlier read, leaves the flag set.
- R9: If end-of-address sets again between the status read and the control write, the pending clear is dropped and that control write leaves the flag set. A set event in the same cycle as the clearing write also wins.
- R10: While `en_i`=0, both flags are 0 on the next edge. This holds even when set events arrive in the same cycle.
- R11: A `start_i` pulse returns the 10-bit address tracker to its fresh state, so the next address byte counts as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; deasserted in step with clk |
| en_i | input | 1 | Interface enable; 0 forces both flags clear |
| irq_en_i | input | 1 | Interrupt enable |
| mode10_i | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| rd_dir_i | input | 1 | Transfer direction, 1 = read |
| start_i | input | 1 | Start condition issued (pulse) |
| rstart_i | input | 1 | Repeated start issued (pulse) |
| addr_sent_i | input | 1 | Address byte transmitted (pulse) |
| nack_i | input | 1 | No acknowledge after a transmitted byte (pulse) |
| sr2_rd_i | input | 1 | Host read of status register 2 (pulse) |
| cr_wr_i | input | 1 | Host write of control register (pulse) |
| ack_fail_o | output | 1 | Acknowledge-failure flag |
| addr_end_o | output | 1 | End-of-address flag |
| irq_o | output | 1 | Interrupt request |
| stretch_ok_o | output | 1 | SCL may be held low when 1 |

## Verification
Three pairs of events can land in the same cycle:
- A missing acknowledge and the host's status read. Both strike the acknowledge-failure flag.
- A fresh address completion and the control write that would finish a pending clear. Both strike the end-of-address flag.
- The enable dropping and set events arriving.

The bench drives each pair in one cycle. It then judges the flag one edge later: the set must win for the first two pairs, and the disable must win for the last. For the address flag, the bench also sends a second clear write. This confirms that the pending clear was discarded and the flag did not simply lag by a cycle.

// File: rtl/i2cm_flags_pkg.sv
package i2cm_flags_pkg;

  // Progress through a 10-bit address phase.
  typedef enum logic [1:0] {
    PH_FRESH   = 2'd0,  // next address byte is a header
    PH_HDR     = 2'd1,  // header sent, low byte pending
    PH_RESTART = 2'd2,  // repeated start seen, header next
    PH_DONE    = 2'd3   // address phase complete
  } addr_phase_e;

endpackage

// File: rtl/i2cm_addr_phase_trk.sv
module i2cm_addr_phase_trk
  import i2cm_flags_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic mode10_i,
  input  logic rd_dir_i,
  input  logic start_i,
  input  logic rstart_i,
  input  logic addr_sent_i,
  output logic done_o
);

  addr_phase_e ph_q, ph_d;
  logic        ph_upd;

  // Completion is decided from the phase held before this byte.
  always_comb begin
    done_o = 1'b0;
    if (en_i && addr_sent_i) begin
      if (!mode10_i) begin
        done_o = 1'b1;
      end else begin
        unique case (ph_q)
          PH_HDR:     done_o = 1'b1;
          PH_RESTART: done_o = rd_dir_i;
          default:    done_o = 1'b0;
        endcase
      end
    end
  end

  always_comb begin
    ph_d   = ph_q;
    ph_upd = 1'b0;
    if (!en_i || start_i) begin
      ph_d   = PH_FRESH;
      ph_upd = 1'b1;
    end else if (rstart_i) begin
      ph_d   = PH_RESTART;
      ph_upd = 1'b1;
    end else if (addr_sent_i && mode10_i) begin
      ph_upd = 1'b1;
      unique case (ph_q)
        PH_HDR:     ph_d = PH_DONE;
        PH_RESTART: ph_d = rd_dir_i ? PH_DONE : PH_HDR;
        default:    ph_d = PH_HDR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_FRESH;
    end else if (ph_upd) begin
      ph_q <= ph_d;
    end
  end

endmodule

// File: rtl/i2cm_ackfail_flag.sv
module i2cm_ackfail_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic nack_i,
  input  logic sr2_rd_i,
  output logic flag_o
);

  logic flag_q, flag_d, flag_upd;

  // Disable beats set; set beats the read-clear.
  always_comb begin
    flag_upd = !en_i || nack_i || sr2_rd_i;
    if (!en_i) begin
      flag_d = 1'b0;
    end else if (nack_i) begin
      flag_d = 1'b1;
    end else begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_upd) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/i2cm_addr_end_flag.sv
module i2cm_addr_end_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic set_i,
  input  logic sr2_rd_i,
  input  logic cr_wr_i,
  output logic flag_o
);

  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic upd;

  // The read arms the clear only while the flag is set. The arm is
  // consumed by the next control write, and any new set drops it.
  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    if (!en_i) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end else if (set_i) begin
      flag_d = 1'b1;
      arm_d  = 1'b0;
    end else if (cr_wr_i && arm_q) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end else if (sr2_rd_i && flag_q) begin
      arm_d  = 1'b1;
    end
    upd = (flag_d != flag_q) || (arm_d != arm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (upd) begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/i2cm_addr_flags.sv
module i2cm_addr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic irq_en_i,
  input  logic mode10_i,
  input  logic rd_dir_i,
  input  logic start_i,
  input  logic rstart_i,
  input  logic addr_sent_i,
  input  logic nack_i,
  input  logic sr2_rd_i,
  input  logic cr_wr_i,
  output logic ack_fail_o,
  output logic addr_end_o,
  output logic irq_o,
  output logic stretch_ok_o
);

  logic phase_done;

  i2cm_addr_phase_trk u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .mode10_i    (mode10_i),
    .rd_dir_i    (rd_dir_i),
    .start_i     (start_i),
    .rstart_i    (rstart_i),
    .addr_sent_i (addr_sent_i),
    .done_o      (phase_done)
  );

  i2cm_ackfail_flag u_af (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .nack_i   (nack_i),
    .sr2_rd_i (sr2_rd_i),
    .flag_o   (ack_fail_o)
  );

  i2cm_addr_end_flag u_ae (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .set_i    (phase_done),
    .sr2_rd_i (sr2_rd_i),
    .cr_wr_i  (cr_wr_i),
    .flag_o   (addr_end_o)
  );

  assign irq_o        = ack_fail_o & irq_en_i;
  assign stretch_ok_o = ~ack_fail_o;

endmodule

// File: rtl/i2cm_addr_flags_chk.sv
module i2cm_addr_flags_chk (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic irq_en_i,
  input logic mode10_i,
  input logic addr_sent_i,
  input logic nack_i,
  input logic sr2_rd_i,
  input logic cr_wr_i,
  input logic ack_fail_o,
  input logic addr_end_o,
  input logic irq_o,
  input logic stretch_ok_o
);

  p_af_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && nack_i |=> ack_fail_o);

  p_irq_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ack_fail_o && irq_en_i));

  p_af_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && sr2_rd_i && !nack_i |=> !ack_fail_o);

  p_no_stretch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fail_o |-> !stretch_ok_o);

  p_eoa_7bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !mode10_i && addr_sent_i |=> addr_end_o);

  p_eoa_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && addr_end_o && !cr_wr_i |=> addr_end_o);

  p_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!ack_fail_o && !addr_end_o));

endmodule

bind i2cm_addr_flags i2cm_addr_flags_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_i         (en_i),
  .irq_en_i     (irq_en_i),
  .mode10_i     (mode10_i),
  .addr_sent_i  (addr_sent_i),
  .nack_i       (nack_i),
  .sr2_rd_i     (sr2_rd_i),
  .cr_wr_i      (cr_wr_i),
  .ack_fail_o   (ack_fail_o),
  .addr_end_o   (addr_end_o),
  .irq_o        (irq_o),
  .stretch_ok_o (stretch_ok_o)
);

// File: tb/i2cm_addr_flags_test.sv
module i2cm_addr_flags_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0, irq_en_i = 1'b0, mode10_i = 1'b0, rd_dir_i = 1'b0;
  logic start_i = 1'b0, rstart_i = 1'b0, addr_sent_i = 1'b0, nack_i = 1'b0;
  logic sr2_rd_i = 1'b0, cr_wr_i = 1'b0;
  logic ack_fail_o, addr_end_o, irq_o, stretch_ok_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  i2cm_addr_flags uut (.*);

  task automatic chk(input logic got, input logic exp, input string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", what, got, exp);
    end
  endtask

  // Apply the current strobes for one edge, then drop them.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    start_i = 0; rstart_i = 0; addr_sent_i = 0; nack_i = 0;
    sr2_rd_i = 0; cr_wr_i = 0;
  endtask

  task automatic clear_eoa();
    sr2_rd_i = 1; step();
    cr_wr_i = 1; step();
  endtask

  task automatic t_reset();
    chk(ack_fail_o, 0, "R1 reset ack_fail");
    chk(addr_end_o, 0, "R5 reset addr_end");
    chk(irq_o, 0, "R2 reset irq");
    chk(stretch_ok_o, 1, "R4 reset stretch_ok");
  endtask

  task automatic t_ackfail();
    irq_en_i = 0;
    nack_i = 1; step();
    chk(ack_fail_o, 1, "R1 nack sets flag");
    chk(irq_o, 0, "R2 irq masked");
    chk(stretch_ok_o, 0, "R4 no stretch while flag");
    irq_en_i = 1; #1;
    chk(irq_o, 1, "R2 irq enabled");
    nack_i = 1; sr2_rd_i = 1; step();
    chk(ack_fail_o, 1, "R3 set beats read");
    sr2_rd_i = 1; step();
    chk(ack_fail_o, 0, "R3 read clears");
    chk(irq_o, 0, "R2 irq drops");
    chk(stretch_ok_o, 1, "R4 stretch restored");
    irq_en_i = 0;
  endtask

  task automatic t_7bit();
    mode10_i = 0;
    start_i = 1; step();
    addr_sent_i = 1; step();
    chk(addr_end_o, 1, "R5 7-bit single byte");
    cr_wr_i = 1; step();
    chk(addr_end_o, 1, "R8 write without read");
    sr2_rd_i = 1; step();
    chk(addr_end_o, 1, "R8 read alone");
    step();
    chk(addr_end_o, 1, "R8 idle after read");
    cr_wr_i = 1; step();
    chk(addr_end_o, 0, "R8 read then write clears");
  endtask

  task automatic t_10bit_write();
    mode10_i = 1; rd_dir_i = 0;
    start_i = 1; step();
    addr_sent_i = 1; step();
    chk(addr_end_o, 0, "R6 header only");
    addr_sent_i = 1; step();
    chk(addr_end_o, 1, "R6 header plus low");
    clear_eoa();
    chk(addr_end_o, 0, "R8 cleared");
  endtask

  task automatic t_10bit_read();
    mode10_i = 1;
    rstart_i = 1; rd_dir_i = 1; step();
    addr_sent_i = 1; step();
    chk(addr_end_o, 1, "R7 read header after restart");
    clear_eoa();
    rstart_i = 1; rd_dir_i = 0; step();
    addr_sent_i = 1; step();
    chk(addr_end_o, 0, "R7 write header after restart");
    addr_sent_i = 1; step();
    chk(addr_end_o, 1, "R7 write low after restart");
    clear_eoa();
  endtask

  task automatic t_start_reset();
    mode10_i = 1; rd_dir_i = 0;
    start_i = 1; step();
    addr_sent_i = 1; step();
    start_i = 1; step();
    addr_sent_i = 1; step();
    chk(addr_end_o, 0, "R11 start restarts header");
    addr_sent_i = 1; step();
    chk(addr_end_o, 1, "R11 low after new header");
    clear_eoa();
  endtask

  task automatic t_rearm_drop();
    mode10_i = 0;
    addr_sent_i = 1; step();
    sr2_rd_i = 1; step();
    addr_sent_i = 1; step();
    cr_wr_i = 1; step();
    chk(addr_end_o, 1, "R9 resets drop arm");
    sr2_rd_i = 1; step();
    addr_sent_i = 1; cr_wr_i = 1; step();
    chk(addr_end_o, 1, "R9 set beats clear write");
    cr_wr_i = 1; step();
    chk(addr_end_o, 1, "R9 arm gone after collision");
    clear_eoa();
    chk(addr_end_o, 0, "R8 final clear");
  endtask

  task automatic t_disable();
    mode10_i = 0;
    nack_i = 1; addr_sent_i = 1; step();
    chk(ack_fail_o, 1, "R1 flag before disable");
    chk(addr_end_o, 1, "R5 flag before disable");
    en_i = 0; nack_i = 1; addr_sent_i = 1; step();
    chk(ack_fail_o, 0, "R10 disable beats nack");
    chk(addr_end_o, 0, "R10 disable beats addr");
    en_i = 1; step();
    chk(ack_fail_o, 0, "R10 stays clear");
    chk(addr_end_o, 0, "R10 stays clear");
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    en_i = 1;
    step();
    t_ackfail();
    t_7bit();
    t_10bit_write();
    t_10bit_read();
    t_start_reset();
    t_rearm_drop();
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule